// File: doc/BRIEF.md
# Two-Stream Instruction Address Sequencer

This block keeps the fetch addresses for one thread whose instructions are split into two half-bundle streams. Both streams start at the same entry address. The execution-side address climbs toward higher memory. The flow-side address descends toward lower memory. In every cycle each stream's parser reports the byte length of the half-bundle it has just taken, and the block moves that stream's address by that amount. A taken branch places the target entry point into both addresses at once.

Idle cycles are not spent on explicit empty bundles. The padding bits of one stream's half-bundle carry a count of cycles during which the other stream has nothing to issue. The parser decodes that count and presents it to this block. The block then freezes the other stream for that many cycles and drops that stream's issue flag. A count of zero means no skip. Longer idle stretches that the padding cannot encode are covered upstream by a real empty half-bundle.

Top module: `dual_stream_sequencer`

## Requirements
- R1: After a synchronous reset, both addresses equal RESET_ADDR (default 0) and both issue flags are high.
- R2: When `ex_issue` is high and `ex_len_valid` is high in a cycle without a branch, `ex_pc` rises by `ex_len` at the next clock edge.
- R3: When `fl_issue` is high and `fl_len_valid` is high in a cycle without a branch, `fl_pc` falls by `fl_len` at the next clock edge.
- R4: When `br_valid` is high, both addresses take `br_target` at the next clock edge. Any length inputs presented in that cycle have no effect.
- R5: A stream whose length-valid input is low keeps its address.
- R6: When the flow stream takes a half-bundle (`fl_issue` and `fl_len_valid` high, no branch) while the execution stream is not skipping, `ex_skip` is loaded. `ex_issue` is then low for exactly that many following cycles. The same holds with the roles swapped, using `fl_skip`.
- R7: While a stream's issue flag is low, its address holds and its length input is ignored. Its issue flag returns high once the skip count has run out.
- R8: A branch clears both pending skip counts, so both issue flags are high after the branch edge.
- R9: A skip value of 0 leaves the other stream issuing.
- R10: Address arithmetic wraps modulo 2^ADDR_W in both directions.
- R11: The two streams advance independently within the same cycle, each by its own length. Lengths range from 1 to MAX_LEN (32) bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Taken transfer of control this cycle |
| br_target | input | ADDR_W | Entry-point address of the branch target |
| ex_len_valid | input | 1 | Execution half-bundle consumed this cycle |
| ex_len | input | LEN_W | Byte length of that execution half-bundle |
| fl_len_valid | input | 1 | Flow half-bundle consumed this cycle |
| fl_len | input | LEN_W | Byte length of that flow half-bundle |
| ex_skip | input | SKIP_W | Cycles the execution stream idles; taken from the flow half-bundle's padding |
| fl_skip | input | SKIP_W | Cycles the flow stream idles; taken from the execution half-bundle's padding |
| ex_pc | output | ADDR_W | Current execution-stream fetch address |
| ex_issue | output | 1 | Execution stream issues this cycle |
| fl_pc | output | ADDR_W | Current flow-stream fetch address |
| fl_issue | output | 1 | Flow stream issues this cycle |

## Verification
Two cases can fall in the same cycle. First, a branch can arrive while a skip count is still running. The bench starts a five-cycle execution skip and then presents a branch on the next cycle. It then expects both addresses at the target, both issue flags high, and the execution address moving again on the following length. Second, a stream can consume its own half-bundle in the same cycle that it receives a skip count from the other stream. That stream must advance by its length and still go idle for exactly the requested number of cycles. During those idle cycles its length input stays asserted and is expected to have no effect.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } walk_dir_e;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_MAX_LEN = 32;
  localparam int unsigned DEF_SKIP_W  = 4;
endpackage

// File: rtl/stream_walker.sv
module stream_walker
  import seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned LEN_W      = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter walk_dir_e   DIR        = DIR_UP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] target,
  input  logic              step,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] pc
);
  localparam int unsigned PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] len_ext;
  logic [ADDR_W-1:0] moved;

  assign len_ext = {{PAD_W{1'b0}}, len};

  generate
    if (DIR == DIR_UP) begin : g_up
      assign moved = pc + len_ext;
    end else begin : g_down
      assign moved = pc - len_ext;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       pc <= RESET_ADDR;
    else if (load) pc <= target;
    else if (step) pc <= moved;
  end

  // R4: branch target lands in the address register
  p_branch_load_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> pc == $past(target));
  // R5: no step, no movement
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(pc));
endmodule

// File: rtl/skip_counter.sv
module skip_counter
  import seq_pkg::*;
#(
  parameter int unsigned SKIP_W = DEF_SKIP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [SKIP_W-1:0] load_val,
  output logic              ready
);
  logic [SKIP_W-1:0] cnt;
  logic [SKIP_W-1:0] cnt_nxt;

  always_comb begin
    if (clear)              cnt_nxt = '0;
    else if (cnt != '0)     cnt_nxt = cnt - 1'b1;
    else if (load)          cnt_nxt = load_val;
    else                    cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b1;
    end else begin
      cnt   <= cnt_nxt;
      ready <= (cnt_nxt == '0);
    end
  end

  // R7: a running count falls by one per cycle
  p_skip_count_down_r7: assert property (@(posedge clk) disable iff (rst)
    (!clear && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R8: a branch wipes the pending skip
  p_branch_clears_skip_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0 && ready));
  // R7: ready tracks an empty counter
  p_ready_matches_r7: assert property (@(posedge clk) disable iff (rst)
    ready == (cnt == '0));
endmodule

// File: rtl/dual_stream_sequencer.sv
module dual_stream_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned MAX_LEN = DEF_MAX_LEN,
  parameter int unsigned SKIP_W  = DEF_SKIP_W,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              ex_len_valid,
  input  logic [LEN_W-1:0]  ex_len,
  input  logic              fl_len_valid,
  input  logic [LEN_W-1:0]  fl_len,
  input  logic [SKIP_W-1:0] ex_skip,
  input  logic [SKIP_W-1:0] fl_skip,
  output logic [ADDR_W-1:0] ex_pc,
  output logic              ex_issue,
  output logic [ADDR_W-1:0] fl_pc,
  output logic              fl_issue
);
  logic ex_take;
  logic fl_take;

  assign ex_take = ex_issue && ex_len_valid && !br_valid;
  assign fl_take = fl_issue && fl_len_valid && !br_valid;

  stream_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_ADDR(RESET_ADDR), .DIR(DIR_UP)
  ) i_ex_walker (
    .clk(clk), .rst(rst), .load(br_valid), .target(br_target),
    .step(ex_take), .len(ex_len), .pc(ex_pc)
  );

  stream_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_ADDR(RESET_ADDR), .DIR(DIR_DOWN)
  ) i_fl_walker (
    .clk(clk), .rst(rst), .load(br_valid), .target(br_target),
    .step(fl_take), .len(fl_len), .pc(fl_pc)
  );

  // the flow half-bundle's padding idles the execution stream, and vice versa
  skip_counter #(.SKIP_W(SKIP_W)) i_ex_skip (
    .clk(clk), .rst(rst), .clear(br_valid), .load(fl_take),
    .load_val(ex_skip), .ready(ex_issue)
  );

  skip_counter #(.SKIP_W(SKIP_W)) i_fl_skip (
    .clk(clk), .rst(rst), .clear(br_valid), .load(ex_take),
    .load_val(fl_skip), .ready(fl_issue)
  );

  // R2: execution address climbs by the consumed length
  p_ex_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (ex_issue && ex_len_valid && !br_valid) |=>
      ex_pc == $past(ex_pc) + ADDR_W'($past(ex_len)));
  // R3: flow address descends by the consumed length
  p_fl_retreat_r3: assert property (@(posedge clk) disable iff (rst)
    (fl_issue && fl_len_valid && !br_valid) |=>
      fl_pc == $past(fl_pc) - ADDR_W'($past(fl_len)));
  // R7: an idle stream keeps its address
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (!ex_issue && !br_valid) |=> $stable(ex_pc));
  // R6: a nonzero skip from the flow side idles the execution side
  p_skip_load_r6: assert property (@(posedge clk) disable iff (rst)
    (fl_issue && fl_len_valid && !br_valid && ex_issue && ex_skip != '0)
      |=> !ex_issue);
  // R4: both streams share the branch entry point
  p_shared_entry_r4: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> ex_pc == fl_pc);
endmodule

// File: tb/test_dual_stream_sequencer.sv
module test_dual_stream_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_valid = 1'b0;
  logic [31:0] br_target = '0;
  logic        ex_len_valid = 1'b0;
  logic [5:0]  ex_len = '0;
  logic        fl_len_valid = 1'b0;
  logic [5:0]  fl_len = '0;
  logic [3:0]  ex_skip = '0;
  logic [3:0]  fl_skip = '0;
  logic [31:0] ex_pc;
  logic        ex_issue;
  logic [31:0] fl_pc;
  logic        fl_issue;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_stream_sequencer i_dual_stream_sequencer (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_target(br_target),
    .ex_len_valid(ex_len_valid), .ex_len(ex_len),
    .fl_len_valid(fl_len_valid), .fl_len(fl_len),
    .ex_skip(ex_skip), .fl_skip(fl_skip),
    .ex_pc(ex_pc), .ex_issue(ex_issue), .fl_pc(fl_pc), .fl_issue(fl_issue)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic br, input logic [31:0] tgt,
                     input logic exv, input logic [5:0] exl,
                     input logic flv, input logic [5:0] fll,
                     input logic [3:0] exs, input logic [3:0] fls);
    @(negedge clk);
    br_valid = br; br_target = tgt;
    ex_len_valid = exv; ex_len = exl;
    fl_len_valid = flv; fl_len = fll;
    ex_skip = exs; fl_skip = fls;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 ex_pc", ex_pc, 32'h0);
    chk("R1 fl_pc", fl_pc, 32'h0);
    chk("R1 ex_issue", 32'(ex_issue), 32'd1);
    chk("R1 fl_issue", 32'(fl_issue), 32'd1);
  endtask

  task automatic t_advance();
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, 0);
    chk("R4 ex_pc", ex_pc, 32'h1000);
    chk("R4 fl_pc", fl_pc, 32'h1000);
    cyc(0, 0, 1, 5, 1, 7, 0, 0);
    chk("R2 ex_pc", ex_pc, 32'h1005);
    chk("R3 fl_pc", fl_pc, 32'h0FF9);
    cyc(0, 0, 1, 32, 1, 1, 0, 0);
    chk("R11 ex_pc len32", ex_pc, 32'h1025);
    chk("R11 fl_pc len1", fl_pc, 32'h0FF8);
    cyc(0, 0, 1, 1, 0, 9, 0, 0);
    chk("R2 ex_pc alone", ex_pc, 32'h1026);
    chk("R5 fl_pc holds", fl_pc, 32'h0FF8);
  endtask

  task automatic t_hold();
    cyc(0, 0, 0, 12, 0, 12, 0, 0);
    chk("R5 ex_pc", ex_pc, 32'h1026);
    chk("R5 fl_pc", fl_pc, 32'h0FF8);
  endtask

  task automatic t_branch_override();
    cyc(1, 32'h2000, 1, 4, 1, 4, 3, 3);
    chk("R4 ex_pc override", ex_pc, 32'h2000);
    chk("R4 fl_pc override", fl_pc, 32'h2000);
    chk("R4 ex_issue", 32'(ex_issue), 32'd1);
    chk("R4 fl_issue", 32'(fl_issue), 32'd1);
  endtask

  task automatic t_skip_ex();
    cyc(0, 0, 1, 4, 1, 2, 3, 0);
    chk("R6 ex_pc same cycle", ex_pc, 32'h2004);
    chk("R6 fl_pc", fl_pc, 32'h1FFE);
    chk("R6 ex_issue low", 32'(ex_issue), 32'd0);
    chk("R6 fl_issue high", 32'(fl_issue), 32'd1);
    for (int i = 1; i <= 3; i++) begin
      cyc(0, 0, 1, 8, 1, 2, 0, 0);
      chk("R7 ex_pc held", ex_pc, 32'h2004);
      chk("R7 ex_issue", 32'(ex_issue), (i == 3) ? 32'd1 : 32'd0);
      chk("R11 fl_pc runs", fl_pc, 32'h1FFE - 32'(2 * i));
    end
    cyc(0, 0, 1, 8, 1, 2, 0, 0);
    chk("R7 ex_pc resumes", ex_pc, 32'h200C);
    chk("R3 fl_pc", fl_pc, 32'h1FF6);
  endtask

  task automatic t_skip_fl();
    cyc(0, 0, 1, 6, 1, 4, 0, 2);
    chk("R6 fl_pc same cycle", fl_pc, 32'h1FF2);
    chk("R6 fl_issue low", 32'(fl_issue), 32'd0);
    chk("R6 ex_pc", ex_pc, 32'h2012);
    cyc(0, 0, 0, 0, 1, 4, 0, 0);
    chk("R7 fl_pc held", fl_pc, 32'h1FF2);
    chk("R7 fl_issue low", 32'(fl_issue), 32'd0);
    cyc(0, 0, 0, 0, 1, 4, 0, 0);
    chk("R7 fl_issue back", 32'(fl_issue), 32'd1);
    chk("R7 fl_pc held 2", fl_pc, 32'h1FF2);
    cyc(0, 0, 0, 0, 1, 4, 0, 0);
    chk("R7 fl_pc resumes", fl_pc, 32'h1FEE);
  endtask

  task automatic t_skip_zero();
    cyc(0, 0, 0, 0, 1, 2, 0, 0);
    chk("R9 ex_issue stays", 32'(ex_issue), 32'd1);
    chk("R9 fl_pc", fl_pc, 32'h1FEC);
  endtask

  task automatic t_branch_during_skip();
    cyc(0, 0, 0, 0, 1, 2, 5, 0);
    chk("R6 ex_issue low before br", 32'(ex_issue), 32'd0);
    cyc(1, 32'h3000, 1, 4, 1, 4, 0, 0);
    chk("R8 ex_pc", ex_pc, 32'h3000);
    chk("R8 fl_pc", fl_pc, 32'h3000);
    chk("R8 ex_issue", 32'(ex_issue), 32'd1);
    chk("R8 fl_issue", 32'(fl_issue), 32'd1);
    cyc(0, 0, 1, 4, 0, 0, 0, 0);
    chk("R8 ex_pc moves", ex_pc, 32'h3004);
  endtask

  task automatic t_wrap();
    cyc(1, 32'hFFFF_FFF0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 32, 0, 0, 0, 0);
    chk("R10 ex_pc wrap", ex_pc, 32'h0000_0010);
    cyc(1, 32'h0000_0008, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 16, 0, 0);
    chk("R10 fl_pc wrap", fl_pc, 32'hFFFF_FFF8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_advance();
    t_hold();
    t_branch_override();
    t_skip_ex();
    t_skip_fl();
    t_skip_zero();
    t_branch_during_skip();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule